// File: doc/BRIEF.md
# Dual-Channel SAR ADC Conversion Sequencer

This block drives a two-input serial successive-approximation converter that is set to manual conversion triggering and manual input selection. It owns the whole serial link (bit clock, active-low frame strobe, command out, data in) and the two handshake pins of the converter: a conversion-start output and an end-of-conversion input. Right after reset it programs the converter with a single setup word. From then on it serves one conversion request at a time.

A request names input 0 or input 1. The sequencer first sends a word that selects that input. It then pulses the conversion-start pin low and waits for the converter to report the end of conversion, giving up after a bounded number of cycles. It then sends the read command and captures the 16-bit word that comes back in the same frame. That word, minus a DC offset supplied on a port, is presented for one cycle along with the input number that was asked for. Words that arrive while the setup or select commands are being shifted out are thrown away. A sample taken for one input can therefore never come out tagged as the other, even when requests for the two inputs follow each other directly.

Top module: `adc_pair_sequencer`

## Requirements
- R1: After reset is released, exactly one serial frame carrying the word 0xE7BD is sent before any request is taken, and `busy` stays high until that frame has finished.
- R2: Each frame holds the frame strobe low for 17 bit periods. The first period is a delay bit. The next 16 carry the word MSB first, and the bit clock shows 17 rising edges per frame. When no frame is running, the bit clock is low and the frame strobe is high.
- R3: One bit period lasts DIV+1 system clocks (2 with the default DIV=1). Inside a frame, consecutive rising edges of the bit clock are DIV+1 clocks apart.
- R4: A conversion sends the select word first: 0x0000 for input 0, 0x1000 for input 1, with the input number in bit 12. The conversion-start pulse begins only after that frame has ended and ends before the next frame starts. The next frame carries the read command 0xD000. A conversion sends exactly these two frames.
- R5: The conversion-start output idles high and goes low for exactly CONV_LOW system clocks once per conversion.
- R6: The read-command frame does not start until the end-of-conversion input has been seen high after the conversion-start pulse.
- R7: When the read frame ends, `result_valid` is high for exactly one cycle. With it, `result_data` equals the word received in the read frame minus `dc_offset`, modulo 2^16, and `result_chan` equals the requested input.
- R8: Words received during the setup frame or a select frame never raise `result_valid` and never appear in `result_data`.
- R9: A request is taken only while `busy` is low. `busy` rises on the cycle after a request is taken. `start` pulses while busy start nothing and do not change the input being converted.
- R10: If the end-of-conversion input stays low for EOC_TIMEOUT clocks after the conversion-start pulse, `timeout_err` pulses for one cycle, no read frame is sent, no result is produced and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, taken when `busy` is low |
| chan | input | 1 | Input to convert (0 or 1) |
| dc_offset | input | 16 | Value subtracted from each captured sample |
| busy | output | 1 | High while setup or a conversion is running |
| result_valid | output | 1 | One-cycle strobe for a new sample |
| result_data | output | 16 | Offset-corrected sample |
| result_chan | output | 1 | Input the sample belongs to |
| timeout_err | output | 1 | One-cycle pulse when end-of-conversion never arrives |
| sclk | output | 1 | Serial bit clock, idles low |
| fs_n | output | 1 | Active-low frame strobe |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial sample data from the converter |
| conv_n | output | 1 | Active-low conversion-start pulse |
| eoc | input | 1 | End-of-conversion flag from the converter, high when done |

## Verification
The assertions assume that the converter pulls end-of-conversion low within CONV_LOW-2 clocks of the conversion-start falling edge, so that the two-flop synchronizer never shows a stale high once the pulse ends. They also assume that `miso` changes only on falling bit-clock edges. The bench's converter model lowers end-of-conversion on the first falling system-clock edge after conversion-start goes low. It updates `miso` on each falling bit-clock edge and returns recognisable junk words in every frame other than the first one after a finished conversion. Requests are only raised while `busy` is low, except in the one scenario that checks that requests are ignored while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] SETUP_WORD = 16'hE7BD;
    localparam logic [WORD_W-1:0] READ_CMD   = 16'hD000;

    typedef enum logic [2:0] {
        ST_SETUP,
        ST_SETUP_WAIT,
        ST_IDLE,
        ST_SEL_WAIT,
        ST_PULSE,
        ST_EOC_WAIT,
        ST_READ_WAIT
    } seq_state_e;

    typedef struct packed {
        logic              chan;
        logic [WORD_W-1:0] data;
    } sample_t;

    // Select word: input number sits in bit 12, all else zero.
    function automatic logic [WORD_W-1:0] select_word(input logic ch);
        return {3'b000, ch, 12'h000};
    endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_seq_pkg::*;
#(
    parameter int DIV = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] tx_word,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              fs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int BIT_CYC = DIV + 1;
    localparam int CNT_W   = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam int LOW_CYC = BIT_CYC / 2;
    localparam int SLOTS   = WORD_W + 1;
    localparam int SLOT_W  = $clog2(SLOTS + 1);

    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              wrap;

    assign wrap = active && (cnt == CNT_W'(BIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            slot   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    slot   <= '0;
                    tx_sh  <= tx_word;
                end
            end else if (wrap) begin
                cnt <= '0;
                if (slot != '0) begin
                    rx_sh <= {rx_sh[WORD_W-2:0], miso};
                    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
                if (slot == SLOT_W'(WORD_W)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rx_word = rx_sh;
    assign fs_n    = !active;
    assign sclk    = active && (cnt >= CNT_W'(LOW_CYC));
    assign mosi    = active && (slot != '0) && tx_sh[WORD_W-1];

    // Checker counter: cycles spent in the current frame.
    localparam int FRAME_CYC = SLOTS * BIT_CYC;
    logic [$clog2(FRAME_CYC + 2)-1:0] frame_len;
    always_ff @(posedge clk) begin
        if (rst || !active) frame_len <= '0;
        else                frame_len <= frame_len + 1'b1;
    end

    p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (frame_len == ($bits(frame_len))'(FRAME_CYC)));

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_LOW    = 4,
    parameter int EOC_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chan,
    input  logic [WORD_W-1:0] dc_offset,
    input  logic              eoc_s,
    input  logic              xfer_active,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] xfer_rx,
    output logic              xfer_go,
    output logic [WORD_W-1:0] xfer_tx,
    output logic              conv_n,
    output logic              busy,
    output logic              result_valid,
    output sample_t           result,
    output logic              timeout_err
);
    localparam int LIMIT = (CONV_LOW > EOC_TIMEOUT) ? CONV_LOW : EOC_TIMEOUT;
    localparam int CW    = $clog2(LIMIT + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          chan_q;

    always_comb begin
        xfer_go = 1'b0;
        xfer_tx = READ_CMD;
        unique case (state)
            ST_SETUP: begin
                xfer_go = 1'b1;
                xfer_tx = SETUP_WORD;
            end
            ST_IDLE: begin
                xfer_go = start;
                xfer_tx = select_word(chan);
            end
            ST_EOC_WAIT: begin
                xfer_go = eoc_s;
                xfer_tx = READ_CMD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_SETUP;
            cnt          <= '0;
            chan_q       <= 1'b0;
            conv_n       <= 1'b1;
            result_valid <= 1'b0;
            result       <= '0;
            timeout_err  <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            timeout_err  <= 1'b0;
            unique case (state)
                ST_SETUP:      state <= ST_SETUP_WAIT;
                ST_SETUP_WAIT: if (xfer_done) state <= ST_IDLE;
                ST_IDLE: begin
                    if (start) begin
                        chan_q <= chan;
                        state  <= ST_SEL_WAIT;
                    end
                end
                ST_SEL_WAIT: begin
                    // Received word of the select frame is dropped here.
                    if (xfer_done) begin
                        conv_n <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (cnt == CW'(CONV_LOW - 1)) begin
                        conv_n <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_EOC_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EOC_WAIT: begin
                    if (eoc_s) begin
                        state <= ST_READ_WAIT;
                    end else if (cnt == CW'(EOC_TIMEOUT - 1)) begin
                        timeout_err <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ_WAIT: begin
                    if (xfer_done) begin
                        result_valid <= 1'b1;
                        result.chan  <= chan_q;
                        result.data  <= xfer_rx - dc_offset;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // Checker counter: length of the current conversion-start low phase.
    logic [CW-1:0] low_len;
    always_ff @(posedge clk) begin
        if (rst || conv_n) low_len <= '0;
        else               low_len <= low_len + 1'b1;
    end

    p_go_engine_idle_r9: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> !xfer_active);

    p_read_after_eoc_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && xfer_tx == READ_CMD) |-> eoc_s);

    p_conv_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_n) |-> (low_len == CW'(CONV_LOW)));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    p_valid_from_read_r8: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ($past(state) == ST_READ_WAIT && $past(xfer_done)));

    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (!busy && !result_valid));

endmodule

// File: rtl/adc_pair_sequencer.sv
module adc_pair_sequencer
    import adc_seq_pkg::*;
#(
    parameter int DIV         = 1,
    parameter int CONV_LOW    = 4,
    parameter int EOC_TIMEOUT = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        chan,
    input  logic [15:0] dc_offset,
    output logic        busy,
    output logic        result_valid,
    output logic [15:0] result_data,
    output logic        result_chan,
    output logic        timeout_err,
    output logic        sclk,
    output logic        fs_n,
    output logic        mosi,
    input  logic        miso,
    output logic        conv_n,
    input  logic        eoc
);
    logic              eoc_s;
    logic              xfer_go;
    logic              xfer_active;
    logic              xfer_done;
    logic [WORD_W-1:0] xfer_tx;
    logic [WORD_W-1:0] xfer_rx;
    sample_t           result;

    adc_eoc_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (eoc),
        .sync_out (eoc_s)
    );

    adc_spi_frame #(.DIV(DIV)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .go      (xfer_go),
        .tx_word (xfer_tx),
        .active  (xfer_active),
        .done    (xfer_done),
        .rx_word (xfer_rx),
        .sclk    (sclk),
        .fs_n    (fs_n),
        .mosi    (mosi),
        .miso    (miso)
    );

    adc_conv_fsm #(.CONV_LOW(CONV_LOW), .EOC_TIMEOUT(EOC_TIMEOUT)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .chan         (chan),
        .dc_offset    (dc_offset),
        .eoc_s        (eoc_s),
        .xfer_active  (xfer_active),
        .xfer_done    (xfer_done),
        .xfer_rx      (xfer_rx),
        .xfer_go      (xfer_go),
        .xfer_tx      (xfer_tx),
        .conv_n       (conv_n),
        .busy         (busy),
        .result_valid (result_valid),
        .result       (result),
        .timeout_err  (timeout_err)
    );

    assign result_data = result.data;
    assign result_chan = result.chan;

endmodule

// File: tb/adc_pair_sequencer_tb.sv
module adc_pair_sequencer_tb;
    localparam int DIV      = 1;
    localparam int BITP     = DIV + 1;
    localparam int CONV_LOW = 4;
    localparam int TMO      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        chan = 1'b0;
    logic [15:0] dc_offset = 16'h0000;
    logic        busy, result_valid, result_chan, timeout_err;
    logic [15:0] result_data;
    logic        sclk, fs_n, mosi, conv_n;
    logic        miso = 1'b0;
    logic        eoc = 1'b1;

    always #2 clk = ~clk;

    adc_pair_sequencer #(.DIV(DIV), .CONV_LOW(CONV_LOW), .EOC_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .dc_offset(dc_offset),
        .busy(busy), .result_valid(result_valid), .result_data(result_data),
        .result_chan(result_chan), .timeout_err(timeout_err),
        .sclk(sclk), .fs_n(fs_n), .mosi(mosi), .miso(miso),
        .conv_n(conv_n), .eoc(eoc)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- converter model and monitors ----------------
    int          cyc = 0;
    logic [15:0] frame_word [0:63];
    int          frame_start[0:63];
    int          frame_end  [0:63];
    int          frame_edges[0:63];
    int          frame_pbad [0:63];
    int          nframes = 0;
    logic [15:0] cur_rx;
    logic [15:0] miso_word;
    int          edges, bitn, last_rise, pbad, fstart;
    bit          in_frame = 0;
    logic [15:0] sample [0:1];
    bit          sel_ch = 0;
    bit          fresh = 0;
    bit          eoc_hold = 0;
    int          eoc_delay = 10;
    int          ecnt = 0;
    int          eoc_rise = 0;
    int          conv_fall = 0, conv_rise = 0, conv_w = 0, low_cnt = 0, nconv = 0;
    bit          conv_prev = 1;
    int          nvalid = 0, ndouble = 0, nto = 0;
    bit          valid_prev = 0;
    logic [15:0] last_data;
    logic        last_chan;
    bit          sclk_idle_bad = 0;

    always @(negedge fs_n) begin
        in_frame  = 1;
        cur_rx    = 16'h0;
        edges     = 0;
        bitn      = 0;
        pbad      = 0;
        fstart    = cyc;
        miso      = 1'b0;
        if (fresh) begin
            miso_word = sample[sel_ch];
            fresh     = 0;
        end else begin
            miso_word = 16'hBA00 | 16'(nframes[7:0]);
        end
    end

    always @(posedge sclk) if (!fs_n) begin
        if (edges >= 1) begin
            cur_rx = {cur_rx[14:0], mosi};
            if (cyc - last_rise != BITP) pbad++;
        end
        last_rise = cyc;
        edges++;
    end

    always @(negedge sclk) if (!fs_n && bitn < 16) begin
        miso = miso_word[15 - bitn];
        bitn++;
    end

    always @(posedge fs_n) if (in_frame) begin
        in_frame = 0;
        if (nframes < 64) begin
            frame_word[nframes]  = cur_rx;
            frame_start[nframes] = fstart;
            frame_end[nframes]   = cyc;
            frame_edges[nframes] = edges;
            frame_pbad[nframes]  = pbad;
        end
        if (nframes > 0 && (cur_rx == 16'h0000 || cur_rx == 16'h1000)) sel_ch = cur_rx[12];
        nframes++;
    end

    always @(negedge clk) begin
        cyc++;
        if (fs_n && sclk) sclk_idle_bad = 1;
        // conversion-start monitor
        if (!conv_n) low_cnt++;
        if (conv_prev && !conv_n) begin conv_fall = cyc; low_cnt = 1; end
        if (!conv_prev && conv_n) begin conv_rise = cyc; conv_w = low_cnt; nconv++; end
        conv_prev = conv_n;
        // end-of-conversion model
        if (!conv_n) begin
            eoc  = 1'b0;
            ecnt = 0;
        end else if (!eoc && !eoc_hold) begin
            ecnt++;
            if (ecnt >= eoc_delay) begin
                eoc      = 1'b1;
                eoc_rise = cyc;
                fresh    = 1;
            end
        end
        // result monitor
        if (result_valid) begin
            nvalid++;
            last_data = result_data;
            last_chan = result_chan;
            if (valid_prev) ndouble++;
        end
        valid_prev = result_valid;
        if (timeout_err) nto++;
    end

    // ---------------- helpers ----------------
    task automatic request(input bit ch);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1;
        chan  = ch;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic check_frame(input int idx, input logic [15:0] exp);
        chk(frame_word[idx] == exp, "R4 frame word", 32'(frame_word[idx]), 32'(exp));
        chk(frame_edges[idx] == 17, "R2 rising edges per frame", 32'(frame_edges[idx]), 32'd17);
        chk(frame_end[idx] - frame_start[idx] == 17 * BITP, "R2 strobe low length",
            32'(frame_end[idx] - frame_start[idx]), 32'(17 * BITP));
        chk(frame_pbad[idx] == 0, "R3 bit period", 32'(frame_pbad[idx]), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_setup();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(conv_n === 1'b1 && fs_n === 1'b1 && sclk === 1'b0 && result_valid === 1'b0,
            "R5 R2 reset outputs", {28'h0, conv_n, fs_n, sclk, result_valid}, 32'hC);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R1 busy during setup", 32'(busy), 32'd1);
        wait_idle(200);
        chk(nframes == 1, "R1 single setup frame", 32'(nframes), 32'd1);
        check_frame(0, 16'hE7BD);
        chk(nvalid == 0, "R8 setup word not returned", 32'(nvalid), 32'd0);
        chk(sclk_idle_bad == 0, "R2 clock idle low", 32'(sclk_idle_bad), 32'd0);
    endtask

    task automatic t_convert(input bit ch, input logic [15:0] smp, input logic [15:0] off, input int dly);
        int f0, v0, c0;
        logic [15:0] exp;
        f0 = nframes; v0 = nvalid; c0 = nconv;
        sample[ch] = smp;
        dc_offset  = off;
        eoc_delay  = dly;
        request(ch);
        wait_idle(1000);
        repeat (3) @(negedge clk);
        exp = smp - off;
        chk(nvalid == v0 + 1, "R7 one result", 32'(nvalid - v0), 32'd1);
        chk(last_chan == ch, "R7 result channel", 32'(last_chan), 32'(ch));
        chk(last_data == exp, "R7 R8 result data", 32'(last_data), 32'(exp));
        chk(nframes == f0 + 2, "R4 two frames", 32'(nframes - f0), 32'd2);
        check_frame(f0, ch ? 16'h1000 : 16'h0000);
        check_frame(f0 + 1, 16'hD000);
        chk(nconv == c0 + 1 && conv_fall > frame_end[f0] && conv_rise <= frame_start[f0 + 1],
            "R4 pulse between frames", 32'(conv_fall), 32'(frame_end[f0]));
        chk(conv_w == CONV_LOW, "R5 pulse width", 32'(conv_w), 32'(CONV_LOW));
        chk(frame_start[f0 + 1] > eoc_rise, "R6 read after eoc", 32'(frame_start[f0 + 1]), 32'(eoc_rise));
        chk(ndouble == 0, "R7 single cycle valid", 32'(ndouble), 32'd0);
    endtask

    task automatic t_busy_ignore();
        int f0, v0;
        f0 = nframes; v0 = nvalid;
        sample[0] = 16'h0F0F;
        sample[1] = 16'h7777;
        dc_offset = 16'h0000;
        eoc_delay = 30;
        request(1'b0);
        for (int i = 0; i < 12; i++) begin
            start = 1'b1;
            chan  = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        wait_idle(1000);
        repeat (100) @(negedge clk);
        chk(nframes == f0 + 2, "R9 no extra frames", 32'(nframes - f0), 32'd2);
        chk(frame_word[f0] == 16'h0000, "R9 channel kept", 32'(frame_word[f0]), 32'h0);
        chk(nvalid == v0 + 1 && last_chan == 1'b0, "R9 result channel kept", 32'(last_chan), 32'd0);
        chk(last_data == 16'h0F0F, "R9 result data", 32'(last_data), 32'h0F0F);
    endtask

    task automatic t_timeout();
        int f0, v0, t0;
        f0 = nframes; v0 = nvalid; t0 = nto;
        eoc_hold = 1;
        request(1'b1);
        wait_idle(TMO + 200);
        repeat (20) @(negedge clk);
        chk(nto == t0 + 1, "R10 timeout pulse", 32'(nto - t0), 32'd1);
        chk(nvalid == v0, "R10 no result", 32'(nvalid - v0), 32'd0);
        chk(nframes == f0 + 1, "R10 no read frame", 32'(nframes - f0), 32'd1);
        chk(busy === 1'b0, "R10 back to idle", 32'(busy), 32'd0);
        eoc_hold = 0;
    endtask

    initial begin
        sample[0] = 16'h0000;
        sample[1] = 16'h0000;
        t_reset_setup();
        t_convert(1'b0, 16'h4321, 16'h0000, 10);
        t_convert(1'b1, 16'h8001, 16'h0100, 5);
        // back to back, alternating inputs
        t_convert(1'b1, 16'h1234, 16'h0000, 3);
        t_convert(1'b0, 16'hABCD, 16'h0000, 3);
        // offset larger than sample wraps modulo 2^16
        t_convert(1'b0, 16'h0005, 16'h0010, 8);
        // long end-of-conversion wait within the timeout
        t_convert(1'b1, 16'hFFFF, 16'h0001, 50);
        t_busy_ignore();
        t_timeout();
        t_convert(1'b1, 16'h5A5A, 16'h0002, 4);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule